// File: doc/BRIEF.md
# Round-Robin DMA Message Sequencer

This block sits between eight receive channels and a DMA engine. Each channel owns a buffer that holds one finished message. A message is written into it by a valid strobe that carries the channel number, a data word and a CRC. When the message is stored, it is stamped with the current value of a free-running counter. A rotating pointer visits the channels one at a time. It passes over any channel whose DMA enable input is low, and over any channel that holds nothing. At the first channel that has a message, it copies that message into three read registers and waits there.

The DMA engine reads the data, CRC and timestamp registers through a simple read port. The reads may come in any order. When all three have been read, the message is consumed: the channel's buffer is emptied and the pointer moves to the next channel. A single request line tells the DMA engine whether any enabled channel still holds a message.

If a new message reaches a buffer that is already full, it overwrites the old one. The exception is the channel the pointer is loading or holding: there the new message is dropped, so the message being read stays intact. In both cases a sticky per-channel overflow flag is raised, and a per-channel clear input lowers it.

Top module: `dma_msg_sequencer`

## Requirements
- R1: After reset all buffers are empty, `dma_req` is 0, every `ovf_flag` bit is 0, and the pointer is parked at channel 0, so the first channel served is the lowest-numbered ready one.
- R2: A pulse of `rx_valid` stores `rx_data` and `rx_crc` in the buffer of channel `rx_chan`. It also stores the timestamp counter's value at that clock edge. The counter is 0 on the first edge after reset and counts up by one on every edge.
- R3: `dma_req` is 1 exactly when at least one channel with its `dma_en` bit set holds a message. This includes the message currently being read.
- R4: Channels are served in ascending cyclic order (7 wraps to 0), starting from the channel after the last one consumed. While no enabled channel is ready, the pointer does not move.
- R5: A channel whose `dma_en` bit is 0 is never loaded. Its message stays stored and is served once the bit is set.
- R6: `rd_data` is selected by `rd_sel`:
  - 0 gives `{channel[2:0], 5'b0, data[23:0]}`.
  - 1 gives the CRC zero-extended to 32 bits.
  - 2 gives the 32-bit timestamp.
  - 3 gives 0.
  - While no message is loaded, every selector returns 0.
- R7: A loaded message is consumed only after each of selectors 0, 1 and 2 has been read with `rd_en` = 1, in any order. Repeated reads of one selector and reads of selector 3 do not count. Until the message is consumed, the loaded contents stay the same.
- R8: A message arriving at a full buffer that is not loaded or being loaded replaces the old message and sets that channel's `ovf_flag` bit.
- R9: A message arriving at the channel that is loaded, or being loaded, is dropped and sets that channel's `ovf_flag` bit.
- R10: Each `ovf_clr` bit clears its channel's `ovf_flag` bit. When a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a complete message is present |
| rx_chan | input | 3 | Channel number of the incoming message |
| rx_data | input | 24 | Message data |
| rx_crc | input | 8 | Message CRC |
| dma_en | input | 8 | Per-channel DMA enable |
| ovf_clr | input | 8 | Per-channel overflow flag clear |
| rd_en | input | 1 | Read access strobe, counted at the clock edge |
| rd_sel | input | 2 | Read register select: 0 data, 1 CRC, 2 timestamp |
| rd_data | output | 32 | Read register contents (combinational from `rd_sel`) |
| dma_req | output | 1 | Some enabled channel holds a message |
| ovf_flag | output | 8 | Sticky per-channel overflow flags |

## Verification
The main sweep first fills all eight buffers while every enable is low. It then applies each of the 256 enable masks in turn. This separates correct skipping and wrap-around from any fixed or unmasked order, and the channel field of the data register shows which channel was served. Buffers that are left behind by one mask are overwritten by the next fill, which exercises overflow on buffers that are not being read. Dedicated cases try:
- reads in shuffled order, with repeats and with the unused selector, to show that only a full set of three completes a message;
- a write to the channel being read, to tell a drop from an overwrite;
- a flag clear in the same cycle as a new overflow.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CRC  = 2'd1,
    SEL_TS   = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  // Cyclic successor of a channel index.
  function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned num);
    return (cur + 1 >= num) ? 0 : cur + 1;
  endfunction

  // Map a read selector to the bit of the access tracker it marks.
  function automatic logic [2:0] sel_mark(input logic [1:0] sel);
    case (rd_sel_e'(sel))
      SEL_DATA: return 3'b001;
      SEL_CRC:  return 3'b010;
      SEL_TS:   return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/msg_slot.sv
module msg_slot #(
  parameter int DATA_W = 24,
  parameter int CRC_W  = 8,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              protect_i,
  input  logic              consume_i,
  input  logic              ovf_clr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              ovf_o
);

  logic accept;
  logic ovf_event;

  assign accept    = wr_i && !protect_i;
  assign ovf_event = wr_i && full_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      data_o <= '0;
      crc_o  <= '0;
      ts_o   <= '0;
    end else if (accept) begin
      full_o <= 1'b1;
      data_o <= data_i;
      crc_o  <= crc_i;
      ts_o   <= ts_i;
    end else if (consume_i) begin
      full_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_o <= 1'b0;
    end else if (ovf_event) begin
      ovf_o <= 1'b1;
    end else if (ovf_clr_i) begin
      ovf_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rr_scheduler.sv
module rr_scheduler
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ready_i,
  input  logic              done_i,
  output logic [CH_W-1:0]   ptr_o,
  output logic              loaded_o,
  output logic              load_fire_o
);

  logic            any_ready;
  logic [CH_W-1:0] ptr_next;

  assign any_ready   = |ready_i;
  assign load_fire_o = !loaded_o && ready_i[ptr_o];
  assign ptr_next    = CH_W'(wrap_inc(int'(ptr_o), NUM_CH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o    <= '0;
      loaded_o <= 1'b0;
    end else if (loaded_o) begin
      if (done_i) begin
        loaded_o <= 1'b0;
        ptr_o    <= ptr_next;
      end
    end else if (load_fire_o) begin
      loaded_o <= 1'b1;
    end else if (any_ready) begin
      ptr_o <= ptr_next;
    end
  end

endmodule

// File: rtl/read_port.sv
module read_port
  import dma_seq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int DATA_W = 24,
  parameter int CRC_W  = 8,
  parameter int TS_W   = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              loaded_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              done_o,
  output logic [2:0]        flags_o
);

  localparam int PAD_W = REG_W - CH_W - DATA_W;

  logic [REG_W-1:0] data_reg, crc_reg, ts_reg, sel_val;
  logic [2:0]       hit, seen;

  assign hit    = (rd_en_i && loaded_i) ? sel_mark(rd_sel_i) : 3'b000;
  assign seen   = flags_o | hit;
  assign done_o = loaded_i && (&seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_reg <= '0;
      crc_reg  <= '0;
      ts_reg   <= '0;
    end else if (load_i) begin
      data_reg <= {ch_i, {PAD_W{1'b0}}, data_i};
      crc_reg  <= REG_W'(crc_i);
      ts_reg   <= REG_W'(ts_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || done_o) flags_o <= 3'b000;
    else                  flags_o <= seen;
  end

  always_comb begin
    case (rd_sel_e'(rd_sel_i))
      SEL_DATA: sel_val = data_reg;
      SEL_CRC:  sel_val = crc_reg;
      SEL_TS:   sel_val = ts_reg;
      default:  sel_val = '0;
    endcase
    rd_data_o = loaded_i ? sel_val : '0;
  end

endmodule

// File: rtl/dma_msg_sequencer.sv
module dma_msg_sequencer #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 24,
  parameter int CRC_W  = 8,
  parameter int TS_W   = 32,
  parameter int REG_W  = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CH_W-1:0]   rx_chan,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CRC_W-1:0]  rx_crc,
  input  logic [NUM_CH-1:0] dma_en,
  input  logic [NUM_CH-1:0] ovf_clr,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              dma_req,
  output logic [NUM_CH-1:0] ovf_flag
);

  logic [TS_W-1:0]   ts_cnt;
  logic [NUM_CH-1:0] slot_full, ready;
  logic [DATA_W-1:0] slot_data [NUM_CH];
  logic [CRC_W-1:0]  slot_crc  [NUM_CH];
  logic [TS_W-1:0]   slot_ts   [NUM_CH];
  logic [CH_W-1:0]   ptr;
  logic              loaded, load_fire, busy, done;
  logic [2:0]        flags;

  always_ff @(posedge clk) begin
    if (!rst_n) ts_cnt <= '0;
    else        ts_cnt <= ts_cnt + 1'b1;
  end

  assign busy    = loaded || load_fire;
  assign ready   = slot_full & dma_en;
  assign dma_req = |ready;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic sel_here;
    assign sel_here = (ptr == CH_W'(g));
    msg_slot #(.DATA_W(DATA_W), .CRC_W(CRC_W), .TS_W(TS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (rx_valid && (rx_chan == CH_W'(g))),
      .protect_i (busy && sel_here),
      .consume_i (done && sel_here),
      .ovf_clr_i (ovf_clr[g]),
      .data_i    (rx_data),
      .crc_i     (rx_crc),
      .ts_i      (ts_cnt),
      .full_o    (slot_full[g]),
      .data_o    (slot_data[g]),
      .crc_o     (slot_crc[g]),
      .ts_o      (slot_ts[g]),
      .ovf_o     (ovf_flag[g])
    );
  end

  rr_scheduler #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready),
    .done_i      (done),
    .ptr_o       (ptr),
    .loaded_o    (loaded),
    .load_fire_o (load_fire)
  );

  read_port #(.CH_W(CH_W), .DATA_W(DATA_W), .CRC_W(CRC_W), .TS_W(TS_W), .REG_W(REG_W)) u_rport (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_fire),
    .loaded_i  (loaded),
    .ch_i      (ptr),
    .data_i    (slot_data[ptr]),
    .crc_i     (slot_crc[ptr]),
    .ts_i      (slot_ts[ptr]),
    .rd_en_i   (rd_en),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data),
    .done_o    (done),
    .flags_o   (flags)
  );

endmodule

// File: rtl/dma_msg_sequencer_chk.sv
module dma_msg_sequencer_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [CH_W-1:0]   rx_chan,
  input logic [CH_W-1:0]   ptr,
  input logic              loaded,
  input logic              done,
  input logic [2:0]        flags,
  input logic              dma_req,
  input logic [REG_W-1:0]  rd_data,
  input logic [NUM_CH-1:0] ovf_flag
);

  AST_LOADED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> dma_req); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (rd_data == '0)); // R6

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !done) |=> (loaded && $stable(ptr))); // R7

  AST_ADVANCE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!loaded && (int'(ptr) == (int'($past(ptr)) + 1) % NUM_CH))); // R4

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (flags == 3'b000)); // R7

  AST_PROTECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && rx_valid && rx_chan == ptr) |=> ovf_flag[$past(ptr)]); // R9

endmodule

bind dma_msg_sequencer dma_msg_sequencer_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .REG_W(REG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_chan  (rx_chan),
  .ptr      (ptr),
  .loaded   (loaded),
  .done     (done),
  .flags    (flags),
  .dma_req  (dma_req),
  .rd_data  (rd_data),
  .ovf_flag (ovf_flag)
);

// File: tb/dma_msg_sequencer_bench.sv
module dma_msg_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [2:0]  rx_chan = '0;
  logic [23:0] rx_data = '0;
  logic [7:0]  rx_crc = '0;
  logic [7:0]  dma_en = '0;
  logic [7:0]  ovf_clr = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        dma_req;
  logic [7:0]  ovf_flag;

  int checks = 0;
  int failures = 0;
  logic [31:0] tb_ts;

  logic        e_full [8];
  logic [23:0] e_data [8];
  logic [7:0]  e_crc  [8];
  logic [31:0] e_ts   [8];
  logic [7:0]  e_ovf;
  int          start_ch;
  int          hold_ch;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tb_ts <= 32'd0;
    else        tb_ts <= tb_ts + 32'd1;
  end

  dma_msg_sequencer u_dma_msg_sequencer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_chan(rx_chan),
    .rx_data(rx_data), .rx_crc(rx_crc), .dma_en(dma_en), .ovf_clr(ovf_clr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .dma_req(dma_req),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input logic [23:0] d, input logic [7:0] c, input logic [7:0] clr);
    @(negedge clk);
    rx_valid = 1'b1; rx_chan = 3'(ch); rx_data = d; rx_crc = c; ovf_clr = clr;
    for (int j = 0; j < 8; j++) if (clr[j]) e_ovf[j] = 1'b0;
    if (e_full[ch]) e_ovf[ch] = 1'b1;
    if (ch != hold_ch) begin
      e_full[ch] = 1'b1; e_data[ch] = d; e_crc[ch] = c; e_ts[ch] = tb_ts;
    end
    @(negedge clk);
    rx_valid = 1'b0; ovf_clr = '0;
  endtask

  task automatic clear_ovf(input logic [7:0] m);
    @(negedge clk); ovf_clr = m;
    @(negedge clk); ovf_clr = '0;
    e_ovf = e_ovf & ~m;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_sel = s;
    #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_sel = s;
    #1 v = rd_data;
  endtask

  // Predicts the next channel from the cyclic order and checks all three registers (R2, R4, R6).
  task automatic consume();
    int c;
    logic [31:0] v, ex;
    c = -1;
    for (int k = 0; k < 8; k++) begin
      int cc;
      cc = (start_ch + k) % 8;
      if (c < 0 && e_full[cc] && dma_en[cc]) c = cc;
    end
    repeat (12) @(negedge clk);
    if (c < 0) begin
      chk(1'b0, "R4 nothing predicted", 32'(dma_req), 32'd0);
    end else begin
      ex = {3'(c), 5'b0, e_data[c]};
      rd(2'd0, v); chk(v == ex, "R4/R6 data", v, ex);
      ex = {24'b0, e_crc[c]};
      rd(2'd1, v); chk(v == ex, "R2/R6 crc", v, ex);
      rd(2'd2, v); chk(v == e_ts[c], "R2 timestamp", v, e_ts[c]);
      e_full[c] = 1'b0;
      start_ch = (c + 1) % 8;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, ex;
    int pop;
    for (int i = 0; i < 8; i++) begin e_full[i] = 1'b0; e_data[i] = '0; e_crc[i] = '0; e_ts[i] = '0; end
    e_ovf = '0; start_ch = 0; hold_ch = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 chk(dma_req == 1'b0, "R1 req", 32'(dma_req), 32'd0);
    chk(ovf_flag == 8'h00, "R1 ovf", 32'(ovf_flag), 32'd0);
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v); chk(v == 32'd0, "R1/R6 empty read", v, 32'd0);
    end

    // R1, R4: pointer parked at 0, ch2 served before ch5
    send(5, 24'h0A0B0C, 8'h55, 8'h00);
    send(2, 24'h123456, 8'hC3, 8'h00);
    #1 chk(dma_req == 1'b0, "R3 all disabled", 32'(dma_req), 32'd0);
    @(negedge clk); dma_en = 8'hFF;
    #1 chk(dma_req == 1'b1, "R3 request", 32'(dma_req), 32'd1);
    consume();
    consume();
    repeat (2) @(negedge clk);
    #1 chk(dma_req == 1'b0, "R3 drained", 32'(dma_req), 32'd0);

    // R7: shuffled and repeated reads
    send(6, 24'hBEEF01, 8'h3C, 8'h00);
    repeat (12) @(negedge clk);
    rd(2'd2, v); rd(2'd2, v); rd(2'd3, v);
    chk(v == 32'd0, "R6 unused selector", v, 32'd0);
    rd(2'd1, v);
    repeat (2) @(negedge clk);
    #1 chk(dma_req == 1'b1, "R7 not consumed after two kinds", 32'(dma_req), 32'd1);
    ex = {3'd6, 5'b0, 24'hBEEF01};
    peek(2'd0, v); chk(v == ex, "R7 contents held", v, ex);
    rd(2'd0, v);
    repeat (2) @(negedge clk);
    #1 chk(dma_req == 1'b0, "R7 consumed", 32'(dma_req), 32'd0);
    peek(2'd0, v); chk(v == 32'd0, "R6 idle zero", v, 32'd0);
    e_full[6] = 1'b0; start_ch = 7;

    // R5: disabled channel kept, then served after wrap (R4)
    @(negedge clk); dma_en = 8'hFB;
    send(2, 24'h00C0DE, 8'h11, 8'h00);
    repeat (12) @(negedge clk);
    #1 chk(dma_req == 1'b0, "R5 disabled no request", 32'(dma_req), 32'd0);
    peek(2'd0, v); chk(v == 32'd0, "R5 not loaded", v, 32'd0);
    @(negedge clk); dma_en = 8'hFF;
    consume();

    // R4, R5, R8: sweep over every enable mask
    for (int m = 0; m < 256; m++) begin
      @(negedge clk); dma_en = 8'h00;
      for (int ch = 0; ch < 8; ch++)
        send(ch, 24'(m * 977 + ch * 131 + 5), 8'(m ^ (ch * 37)), 8'h00);
      #1 chk(ovf_flag == e_ovf, "R8 overwrite flags", 32'(ovf_flag), 32'(e_ovf));
      @(negedge clk); dma_en = 8'(m);
      #1 chk(dma_req == (m != 0), "R3 sweep request", 32'(dma_req), 32'(m != 0));
      pop = $countones(8'(m));
      for (int k = 0; k < pop; k++) consume();
      repeat (12) @(negedge clk);
      #1 chk(dma_req == 1'b0, "R5 sweep drained", 32'(dma_req), 32'd0);
      peek(2'd0, v); chk(v == 32'd0, "R5 disabled not loaded", v, 32'd0);
      clear_ovf(8'hFF);
    end
    #1 chk(ovf_flag == 8'h00, "R10 cleared", 32'(ovf_flag), 32'd0);

    // R9: write to the channel being read is dropped
    @(negedge clk); dma_en = 8'hFF;
    send(1, 24'h111111, 8'hA1, 8'h00);
    repeat (12) @(negedge clk);
    hold_ch = 1;
    send(1, 24'h222222, 8'hA2, 8'h00);
    #1 chk(ovf_flag[1] == 1'b1, "R9 drop flag", 32'(ovf_flag), 32'h2);
    hold_ch = -1;
    consume();
    repeat (2) @(negedge clk);
    #1 chk(dma_req == 1'b0, "R9 dropped message absent", 32'(dma_req), 32'd0);

    // R10: clear, and set beats clear
    clear_ovf(8'h02);
    #1 chk(ovf_flag == 8'h00, "R10 clear", 32'(ovf_flag), 32'd0);
    @(negedge clk); dma_en = 8'h00;
    send(4, 24'h040404, 8'h44, 8'h00);
    send(4, 24'h050505, 8'h45, 8'h10);
    #1 chk(ovf_flag == 8'h10, "R10 set wins", 32'(ovf_flag), 32'h10);
    clear_ovf(8'h10);
    #1 chk(ovf_flag == 8'h00, "R10 clear after", 32'(ovf_flag), 32'd0);
    @(negedge clk); dma_en = 8'hFF;
    consume();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule